// File: doc/BRIEF.md
# Half-Duplex Programming-Port Serial PHY

This block is the target-side physical layer of a synchronous serial link used for device programming. An external programmer supplies the serial clock, and both sides share a single data wire. The block either listens on that wire or drives it, and never does both at once. Its drive is gated by an output enable, so the pad can be built as a tri-state buffer.

After power-up the link stays inactive until the enable input is raised and the data wire is then seen high for a run of consecutive clocks. Once the link is active, the block turns incoming frames into bytes and reports parity and stop-bit faults with each byte. It also sends bytes handed to it as frames, and it abandons a transmission if another driver pulls the wire low against it. Dropping the enable input closes the link unless the nonvolatile-memory-enable flag is set. In that case only a reset, which stands for power-down, closes it.

Each frame lasts 12 bit periods. It starts with a low start bit, which is followed by eight data bits sent least significant bit first. After the data comes an even-parity bit, and two high stop bits end the frame. The idle line is high. The block samples the wire on the rising clock edge and changes its driven value on the falling edge.

Top module: `prog_link_phy`

## Requirements
- R1: After reset, link_up, data_oe, tx_busy, tx_coll and rx_valid are all 0.
- R2: While en is 1, link_up rises after the rising edge on which data_in has been sampled high for IDLE_CLKS consecutive edges (16 by default). A low sample restarts the count, so 15 high edges are not enough.
- R3: A received frame uses bit index 0 as the start bit (low), indexes 1 to 8 as data bits 0 to 7 (least significant bit first), index 9 as parity, and indexes 10 and 11 as stop bits. rx_valid pulses for exactly one clock after the rising edge that samples index 11, and rx_data then holds the byte.
- R4: rx_perr is 1 with rx_valid when the received parity bit differs from the XOR of the eight data bits (even parity), and 0 otherwise.
- R5: rx_ferr is 1 with rx_valid when either stop bit was sampled low, and 0 when both were high.
- R6: A transmitted frame has the same 12-bit layout as in R3. The parity bit is the XOR of the data, and both stop bits are high. The driven value changes on falling edges, and data_oe is 1 only while a frame is being driven.
- R7: tx_req is accepted on a rising edge when tx_busy is 0. tx_busy then stays 1 from that edge through the edge that samples the second stop bit, and falls on that edge.
- R8: A transmit request made while a receive frame is in progress does not drive the wire. The request is held and is sent once the receive frame has ended.
- R9: If the block drives a high bit but samples data_in low, tx_coll pulses for one clock, tx_busy falls on that edge, and data_oe falls on the next falling edge.
- R10: When en falls, link_up clears on the next rising edge if nvm_en is 0. While nvm_en is 1, link_up stays 1.
- R11: While link_up is 0, tx_req is ignored: tx_busy and data_oe stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock from the programmer |
| rst_n | input | 1 | Active-low asynchronous reset (power-down) |
| en | input | 1 | Link enable request |
| nvm_en | input | 1 | Keeps the link open while set |
| data_in | input | 1 | Sampled level of the shared data wire |
| data_out | output | 1 | Value driven onto the wire when enabled |
| data_oe | output | 1 | Tri-state drive enable for the wire |
| link_up | output | 1 | Link is active |
| rx_valid | output | 1 | One-clock strobe for a received byte |
| rx_data | output | 8 | Received byte |
| rx_perr | output | 1 | Parity mismatch on the received byte |
| rx_ferr | output | 1 | A stop bit of the received byte was low |
| tx_req | input | 1 | Request to send tx_data |
| tx_data | input | 8 | Byte to send |
| tx_busy | output | 1 | A transmit is held or in progress |
| tx_coll | output | 1 | One-clock strobe for an aborted transmit |

## Verification
The bench builds the block with the default IDLE_CLKS of 16, so the real enable run is exercised. This covers the boundary between 15 and 16 idle clocks and a restart of the count after a low glitch. The bench models the shared wire as a wired-AND of the block's drive and a programmer-side driver. This lets it pull the wire low under a high transmitted bit to provoke a collision, and interleave a transmit request with an incoming frame.

// File: rtl/prog_link_phy.sv
module prog_link_phy #(
  parameter int IDLE_CLKS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       nvm_en,
  input  logic       data_in,
  output logic       data_out,
  output logic       data_oe,
  output logic       link_up,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_perr,
  output logic       rx_ferr,
  input  logic       tx_req,
  input  logic [7:0] tx_data,
  output logic       tx_busy,
  output logic       tx_coll
);
  localparam int CW = $clog2(IDLE_CLKS + 1);
  localparam int FRAME = 12;

  logic [CW-1:0] idle_cnt;
  logic          link_q;
  logic [3:0]    rx_cnt;
  logic [7:0]    rx_sr, rx_data_q;
  logic          rx_par, rx_stop1, rx_valid_q, rx_perr_q, rx_ferr_q;
  logic          busy_q, tx_act, coll_q, nx_bit, nx_oe, oe_q, out_q;
  logic [7:0]    tx_hold;
  logic [FRAME-1:0] tx_sr;
  logic [3:0]    tx_cnt;

  wire run     = link_q && (en || nvm_en);
  wire rx_act  = rx_cnt != 4'd0;
  wire tx_go   = busy_q && !tx_act && !rx_act && data_in;
  wire rx_go   = !rx_act && !tx_act && !data_in;
  wire collide = tx_act && oe_q && out_q && !data_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q   <= 1'b0;
      idle_cnt <= '0;
    end else if (!en) begin
      idle_cnt <= '0;
      if (!nvm_en) link_q <= 1'b0;
    end else if (!link_q) begin
      if (!data_in) idle_cnt <= '0;
      else if (idle_cnt == CW'(IDLE_CLKS - 1)) link_q <= 1'b1;
      else idle_cnt <= idle_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt     <= '0;
      rx_sr      <= '0;
      rx_par     <= 1'b0;
      rx_stop1   <= 1'b1;
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
      rx_perr_q  <= 1'b0;
      rx_ferr_q  <= 1'b0;
    end else if (!run) begin
      rx_cnt     <= '0;
      rx_valid_q <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (rx_go) begin
        rx_cnt <= 4'd1;
      end else if (rx_act) begin
        if (rx_cnt <= 4'd8) rx_sr <= {data_in, rx_sr[7:1]};
        if (rx_cnt == 4'd9) rx_par <= data_in;
        if (rx_cnt == 4'd10) rx_stop1 <= data_in;
        if (rx_cnt == 4'd11) begin
          rx_cnt     <= '0;
          rx_valid_q <= 1'b1;
          rx_data_q  <= rx_sr;
          rx_perr_q  <= rx_par != ^rx_sr;
          rx_ferr_q  <= !rx_stop1 || !data_in;
        end else begin
          rx_cnt <= rx_cnt + 4'd1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tx_act  <= 1'b0;
      coll_q  <= 1'b0;
      nx_bit  <= 1'b1;
      nx_oe   <= 1'b0;
      tx_hold <= '0;
      tx_sr   <= '1;
      tx_cnt  <= '0;
    end else if (!run) begin
      busy_q <= 1'b0;
      tx_act <= 1'b0;
      coll_q <= 1'b0;
      nx_oe  <= 1'b0;
    end else begin
      coll_q <= 1'b0;
      if (!busy_q) begin
        if (tx_req) begin
          busy_q  <= 1'b1;
          tx_hold <= tx_data;
        end
      end else if (tx_go) begin
        tx_act <= 1'b1;
        tx_sr  <= {2'b11, ^tx_hold, tx_hold, 1'b0};
        tx_cnt <= 4'(FRAME);
        nx_bit <= 1'b0;
        nx_oe  <= 1'b1;
      end else if (tx_act) begin
        if (collide || tx_cnt == 4'd1) begin
          tx_act <= 1'b0;
          busy_q <= 1'b0;
          nx_oe  <= 1'b0;
          coll_q <= collide;
        end else begin
          tx_sr  <= tx_sr >> 1;
          tx_cnt <= tx_cnt - 4'd1;
          nx_bit <= tx_sr[1];
        end
      end
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_q  <= 1'b0;
      out_q <= 1'b1;
    end else begin
      oe_q  <= nx_oe;
      out_q <= nx_oe ? nx_bit : 1'b1;
    end
  end

  assign data_out = out_q;
  assign data_oe  = oe_q;
  assign link_up  = link_q;
  assign rx_valid = rx_valid_q;
  assign rx_data  = rx_data_q;
  assign rx_perr  = rx_perr_q;
  assign rx_ferr  = rx_ferr_q;
  assign tx_busy  = busy_q;
  assign tx_coll  = coll_q;
endmodule

module prog_link_phy_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic nvm_en,
  input logic link_up,
  input logic data_oe,
  input logic tx_busy,
  input logic tx_coll,
  input logic rx_valid
);
  p_rise_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(en));
  p_rx_one_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  p_oe_needs_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> tx_busy);
  p_no_rx_while_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !data_oe);
  p_coll_drops_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_coll |-> !tx_busy);
  p_coll_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_coll |=> !data_oe && !tx_coll);
  p_nvm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    link_up && nvm_en |=> link_up);
  p_down_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !link_up |-> !tx_busy && !data_oe);
endmodule

bind prog_link_phy prog_link_phy_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .nvm_en(nvm_en), .link_up(link_up),
  .data_oe(data_oe), .tx_busy(tx_busy), .tx_coll(tx_coll), .rx_valid(rx_valid)
);

// File: tb/tb_prog_link_phy.sv
module tb_prog_link_phy;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, nvm_en = 1'b0;
  logic host_drv = 1'b1, tx_req = 1'b0;
  logic [7:0] tx_data = '0;
  logic data_out, data_oe, link_up, rx_valid, rx_perr, rx_ferr, tx_busy, tx_coll;
  logic [7:0] rx_data;
  wire line = data_oe ? (data_out & host_drv) : host_drv;
  int checks = 0, fails = 0;

  always #2ns clk = ~clk;

  prog_link_phy dut (
    .clk(clk), .rst_n(rst_n), .en(en), .nvm_en(nvm_en), .data_in(line),
    .data_out(data_out), .data_oe(data_oe), .link_up(link_up),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ferr(rx_ferr),
    .tx_req(tx_req), .tx_data(tx_data), .tx_busy(tx_busy), .tx_coll(tx_coll)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    #1ns;
    chk("R1", "link_up", link_up, 0);
    chk("R1", "data_oe", data_oe, 0);
    chk("R1", "tx_busy", tx_busy, 0);
    chk("R1", "tx_coll", tx_coll, 0);
    chk("R1", "rx_valid", rx_valid, 0);
  endtask

  task automatic t_enable();
    @(negedge clk); en = 1'b1; host_drv = 1'b1;
    repeat (10) @(posedge clk);
    @(negedge clk); host_drv = 1'b0;
    @(negedge clk); host_drv = 1'b1;
    repeat (15) @(posedge clk);
    #1ns chk("R2", "link_up after 15 idle", link_up, 0);
    @(posedge clk);
    #1ns chk("R2", "link_up after 16 idle", link_up, 1);
  endtask

  task automatic t_rx(input logic [7:0] d, input logic flip, input logic s1, input logic s2);
    logic [11:0] f = {s2, s1, (^d) ^ flip, d, 1'b0};
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); host_drv = f[i];
    end
    @(negedge clk); host_drv = 1'b1;
    chk("R3", "rx_valid", rx_valid, 1);
    chk("R3", "rx_data", rx_data, d);
    chk("R4", "rx_perr", rx_perr, flip);
    chk("R5", "rx_ferr", rx_ferr, !(s1 && s2));
    @(posedge clk);
    #1ns chk("R3", "rx_valid one pulse", rx_valid, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic collect(input logic [7:0] d);
    logic [11:0] got;
    logic [11:0] exp = {2'b11, ^d, d, 1'b0};
    int n = 0;
    while (!data_oe && n < 40) begin @(negedge clk); #1ns; n++; end
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1ns;
      got[i] = line;
      if (i == 10) chk("R7", "busy before last stop", tx_busy, 1);
    end
    chk("R6", "tx frame", got, exp);
    chk("R7", "busy cleared after stop2", tx_busy, 0);
    @(negedge clk); #1ns chk("R6", "oe released", data_oe, 0);
  endtask

  task automatic t_tx(input logic [7:0] d);
    @(negedge clk); tx_req = 1'b1; tx_data = d;
    @(posedge clk); #1ns chk("R7", "busy on accept", tx_busy, 1);
    @(negedge clk); tx_req = 1'b0;
    collect(d);
  endtask

  task automatic t_holdoff();
    logic [11:0] f = {2'b11, ^8'h5A, 8'h5A, 1'b0};
    int oe_seen = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk); host_drv = f[i];
      if (i == 3) begin tx_req = 1'b1; tx_data = 8'hC3; end
      if (i == 4) tx_req = 1'b0;
      #1ns if (data_oe) oe_seen++;
    end
    @(negedge clk); host_drv = 1'b1;
    chk("R8", "no drive during rx", oe_seen, 0);
    chk("R8", "request held busy", tx_busy, 1);
    chk("R8", "rx byte intact", rx_data, 8'h5A);
    collect(8'hC3);
  endtask

  task automatic t_collision();
    int n = 0;
    @(negedge clk); tx_req = 1'b1; tx_data = 8'hFF;
    @(negedge clk); tx_req = 1'b0;
    while (!data_oe && n < 40) begin @(negedge clk); #1ns; n++; end
    @(posedge clk);
    @(negedge clk); host_drv = 1'b0;
    @(posedge clk); #1ns;
    chk("R9", "tx_coll", tx_coll, 1);
    chk("R9", "busy dropped", tx_busy, 0);
    @(negedge clk); host_drv = 1'b1;
    #1ns chk("R9", "oe released", data_oe, 0);
    @(posedge clk); #1ns chk("R9", "coll one pulse", tx_coll, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_disable();
    @(negedge clk); nvm_en = 1'b1; en = 1'b0;
    repeat (5) @(posedge clk);
    #1ns chk("R10", "held by nvm_en", link_up, 1);
    @(negedge clk); nvm_en = 1'b0;
    @(posedge clk); #1ns chk("R10", "link dropped", link_up, 0);
  endtask

  task automatic t_ignore_down();
    int bad = 0;
    @(negedge clk); tx_req = 1'b1; tx_data = 8'h11;
    repeat (3) @(negedge clk);
    tx_req = 1'b0;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk); #1ns if (tx_busy || data_oe) bad++;
    end
    chk("R11", "tx_req ignored while down", bad, 0);
  endtask

  initial begin
    #400000ns;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    t_enable();
    t_rx(8'hA5, 1'b0, 1'b1, 1'b1);
    t_rx(8'h00, 1'b0, 1'b1, 1'b1);
    t_rx(8'hFF, 1'b0, 1'b1, 1'b1);
    t_rx(8'h96, 1'b1, 1'b1, 1'b1);
    t_rx(8'h3C, 1'b0, 1'b0, 1'b1);
    t_rx(8'h81, 1'b0, 1'b1, 1'b0);
    t_tx(8'h3C);
    t_tx(8'h81);
    t_holdoff();
    t_collision();
    t_disable();
    t_ignore_down();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule